// File: doc/BRIEF.md
# Read-After-Write Stall Interlock for a Five-Stage Pipeline

This block is the stall controller of an in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. The pipeline has no bypass network. The block keeps the control side of the stage registers: the decoded instruction in decode, plus the valid bit, register-write enable and destination of each older stage. Every cycle it checks whether a source register that the decode instruction actually reads is the destination of a valid, writing instruction in execute or memory. If so, the decode instruction waits.

While it waits, the block freezes the program counter and the fetch/decode register, and it loads a bubble into the decode/execute register. Older instructions keep moving toward write-back. The register file is assumed to write early in the cycle and read late in it. A producer already in write-back therefore never holds up a reader, so a reader directly behind its producer loses two cycles and one two slots behind loses one.

The write-back stage is exposed at the ports (valid, write enable, destination), so the retirement order and the total cycle count can be observed from outside.

Top module: `pil_interlock`

## Requirements
- R1: An instruction accepted from fetch (fetch_valid high in a cycle with pc_we high) shows up at write-back (wb_valid high, wb_rd equal to its fetch_rd) four cycles after acceptance plus any stall cycles, and instructions retire in fetch order.
- R2: A stall is asserted in a cycle exactly when the decode instruction is valid and one of its used source fields equals the destination of a valid instruction with write enable set in execute or memory.
- R3: The class code on fetch_cls sets which sources are used and whether a destination is written: 2'b00 no-op (no sources, no write), 2'b01 register ALU op (reads rs and rt, writes rd), 2'b10 load (reads rs only, writes rd), 2'b11 store (reads rs and rt, no write); wb_wen reflects the write flag.
- R4: A destination of register 0 never causes a stall, and neither does an older instruction whose write enable is clear.
- R5: A producer in write-back causes no stall for a reader in decode in the same cycle.
- R6: In a stall cycle pc_we is 0, ifid_hold is 1 and idex_bubble is 1, and the decode instruction is held unchanged. In any other cycle pc_we is 1 and both other controls are 0.
- R7: Each stall cycle inserts one bubble into execute while the older stages advance. A reader directly behind its producer stalls 2 cycles, and a reader two slots behind its producer stalls 1 cycle.
- R8: While reset is low, all stages are empty: pc_we is 1, ifid_hold and idex_bubble are 0, and wb_valid is 0. Reset applied during a stall clears the stall at once.
- R9: The sequence ALU r1; load r4 from base r1; ALU r5 from r2,r4; ALU r1 from r3,r1; store with base r5 and data r1 completes in 15 cycles, counted from the first fetch cycle to the last write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Fetch presents a real instruction |
| fetch_cls | input | 2 | Instruction class code (see R3) |
| fetch_rs | input | REG_W | First source register |
| fetch_rt | input | REG_W | Second source register |
| fetch_rd | input | REG_W | Destination register |
| pc_we | output | 1 | Program counter update enable |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| wb_valid | output | 1 | Write-back stage holds a real instruction |
| wb_wen | output | 1 | Write-back instruction writes a register |
| wb_rd | output | REG_W | Write-back destination |

## Verification
The bench goes after the distance cases: a reader one slot behind its producer (it must stall twice, and a design that forgot the memory-stage compare would stall once and read stale data), two slots behind (one stall), and three slots behind (no stall; a design that also compared write-back would lose a cycle). It also checks the false-dependence cases: register 0, stores and no-ops that write nothing, and the unused rt field of a load. A design that got any of these wrong would stall where it must not, and the total cycle count would come out too large. Reset during a live stall must release fetch at once, and the retirement order must survive the bubbles; a design that did not hold decode would drop or duplicate an instruction.

// File: rtl/pil_pkg.sv
package pil_pkg;
   typedef enum logic [1:0] {
      CLS_NOP   = 2'b00,
      CLS_ALU   = 2'b01,
      CLS_LOAD  = 2'b10,
      CLS_STORE = 2'b11
   } cls_e;

   // stage indices behind decode
   localparam int STG_EX  = 0;
   localparam int STG_MEM = 1;
   localparam int STG_WB  = 2;
   localparam int N_OLDER = 3;
endpackage

// File: rtl/pil_srcuse.sv
module pil_srcuse
   import pil_pkg::*;
(
   input  logic [1:0] cls,
   output logic       use_rs,
   output logic       use_rt,
   output logic       wen
);
   cls_e c;
   assign c = cls_e'(cls);

   // R3: operand usage per class
   always_comb begin
      use_rs = 1'b0;
      use_rt = 1'b0;
      wen    = 1'b0;
      case (c)
         CLS_ALU: begin
            use_rs = 1'b1;
            use_rt = 1'b1;
            wen    = 1'b1;
         end
         CLS_LOAD: begin
            use_rs = 1'b1;
            wen    = 1'b1;
         end
         CLS_STORE: begin
            use_rs = 1'b1;
            use_rt = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pil_cmp.sv
module pil_cmp #(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   input  logic             use_a,
   input  logic             use_b,
   input  logic             old_vld,
   input  logic             old_wen,
   input  logic [REG_W-1:0] old_dst,
   output logic             hit
);
   logic dst_live;
   logic match_a;
   logic match_b;

   // R4: register 0 excluded only when it is hard-wired
   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign dst_live = old_vld && old_wen && (old_dst != '0);
      end else begin : g_zero_soft
         assign dst_live = old_vld && old_wen;
      end
   endgenerate

   assign match_a = use_a && (src_a == old_dst);
   assign match_b = use_b && (src_b == old_dst);
   assign hit     = dst_live && (match_a || match_b);
endmodule

// File: rtl/pil_stages.sv
module pil_stages
   import pil_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            stall,
   input  logic                            f_vld,
   input  logic [1:0]                      f_cls,
   input  logic [REG_W-1:0]                f_rs,
   input  logic [REG_W-1:0]                f_rt,
   input  logic [REG_W-1:0]                f_rd,
   input  logic                            dec_wen,
   output logic                            id_vld,
   output logic [1:0]                      id_cls,
   output logic [REG_W-1:0]                id_rs,
   output logic [REG_W-1:0]                id_rt,
   output logic [REG_W-1:0]                id_rd,
   output logic [N_OLDER-1:0]              old_vld,
   output logic [N_OLDER-1:0]              old_wen,
   output logic [N_OLDER-1:0][REG_W-1:0]   old_dst
);
   typedef struct packed {
      logic             vld;
      logic [1:0]       cls;
      logic [REG_W-1:0] rs;
      logic [REG_W-1:0] rt;
      logic [REG_W-1:0] rd;
   } dec_t;

   typedef struct packed {
      logic             vld;
      logic             wen;
      logic [REG_W-1:0] dst;
   } ctl_t;

   dec_t ifid_q;
   ctl_t stg_q [N_OLDER];
   ctl_t idex_d;

   // bubble in place of the decode instruction on a stall
   assign idex_d = stall ? '0 : '{vld: ifid_q.vld, wen: dec_wen & ifid_q.vld, dst: ifid_q.rd};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifid_q <= '0;
      end else if (!stall) begin
         ifid_q <= '{vld: f_vld, cls: f_cls, rs: f_rs, rt: f_rt, rd: f_rd};
      end
   end

   generate
      for (genvar s = 0; s < N_OLDER; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q[s] <= '0;
            end else begin
               stg_q[s] <= (s == 0) ? idex_d : stg_q[(s == 0) ? 0 : s-1];
            end
         end
         assign old_vld[s] = stg_q[s].vld;
         assign old_wen[s] = stg_q[s].wen;
         assign old_dst[s] = stg_q[s].dst;
      end
   endgenerate

   assign id_vld = ifid_q.vld;
   assign id_cls = ifid_q.cls;
   assign id_rs  = ifid_q.rs;
   assign id_rt  = ifid_q.rt;
   assign id_rd  = ifid_q.rd;

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(ifid_q))
      else $error("decode register changed during stall");

   assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stg_q[STG_EX].vld)
      else $error("no bubble after stall");

   assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stg_q[STG_MEM].vld |=> stg_q[STG_WB].vld)
      else $error("memory stage did not advance");
endmodule

// File: rtl/pil_interlock.sv
module pil_interlock
   import pil_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit SPLIT_RF   = 1'b1,
   parameter bit ZERO_HARD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_valid,
   input  logic [1:0]       fetch_cls,
   input  logic [REG_W-1:0] fetch_rs,
   input  logic [REG_W-1:0] fetch_rt,
   input  logic [REG_W-1:0] fetch_rd,
   output logic             pc_we,
   output logic             ifid_hold,
   output logic             idex_bubble,
   output logic             wb_valid,
   output logic             wb_wen,
   output logic [REG_W-1:0] wb_rd
);
   // with a split-cycle register file write-back needs no compare (R5)
   localparam int N_CMP     = SPLIT_RF ? 2 : 3;
   localparam int MAX_STALL = N_CMP;
   localparam int RUN_W     = $clog2(MAX_STALL + 2);

   initial begin
      assert (REG_W >= 1 && REG_W <= 8) else $error("REG_W out of range");
      assert (N_CMP <= N_OLDER) else $error("compare count exceeds stages");
   end

   logic                          stall;
   logic                          id_vld;
   logic [1:0]                    id_cls;
   logic [REG_W-1:0]              id_rs, id_rt, id_rd;
   logic [N_OLDER-1:0]            old_vld, old_wen;
   logic [N_OLDER-1:0][REG_W-1:0] old_dst;
   logic                          use_rs, use_rt, dec_wen;
   logic [N_CMP-1:0]              hit;

   pil_stages #(.REG_W(REG_W)) stages_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall   (stall),
      .f_vld   (fetch_valid),
      .f_cls   (fetch_cls),
      .f_rs    (fetch_rs),
      .f_rt    (fetch_rt),
      .f_rd    (fetch_rd),
      .dec_wen (dec_wen),
      .id_vld  (id_vld),
      .id_cls  (id_cls),
      .id_rs   (id_rs),
      .id_rt   (id_rt),
      .id_rd   (id_rd),
      .old_vld (old_vld),
      .old_wen (old_wen),
      .old_dst (old_dst)
   );

   pil_srcuse use_i (
      .cls    (id_cls),
      .use_rs (use_rs),
      .use_rt (use_rt),
      .wen    (dec_wen)
   );

   // R2: one comparator per older stage that can still be producing
   generate
      for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
         pil_cmp #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) cmp_i (
            .src_a   (id_rs),
            .src_b   (id_rt),
            .use_a   (use_rs),
            .use_b   (use_rt),
            .old_vld (old_vld[g]),
            .old_wen (old_wen[g]),
            .old_dst (old_dst[g]),
            .hit     (hit[g])
         );
      end
   endgenerate

   assign stall       = id_vld && (|hit);
   assign pc_we       = !stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

   assign wb_valid = old_vld[STG_WB];
   assign wb_wen   = old_wen[STG_WB];
   assign wb_rd    = old_dst[STG_WB];

   // length of the current stall run, for the checker
   logic [RUN_W-1:0] stall_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stall_run <= '0;
      else if (stall) stall_run <= stall_run + 1'b1;
      else            stall_run <= '0;
   end

   assert_stall_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_run <= RUN_W'(MAX_STALL))
      else $error("stall run too long");

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !id_vld |-> pc_we)
      else $error("stall with empty decode");
endmodule

// File: tb/pil_interlock_tb.sv
`timescale 1ns/1ps
module pil_interlock_tb_top;
   localparam int RW = 5;
   localparam int NV = 26;

   typedef struct packed {
      logic       last;
      logic [1:0] cls;
      logic [4:0] rs;
      logic [4:0] rt;
      logic [4:0] rd;
      logic [1:0] stl;
   } vec_t;

   // class: 0 nop, 1 alu, 2 load, 3 store; stl = expected stall cycles in decode
   localparam vec_t VEC [NV] = '{
      // program A: the 15-cycle chain (R9)
      '{1'b0, 2'd1, 5'd2,  5'd3,  5'd1,  2'd0},
      '{1'b0, 2'd2, 5'd1,  5'd0,  5'd4,  2'd2},
      '{1'b0, 2'd1, 5'd2,  5'd4,  5'd5,  2'd2},
      '{1'b0, 2'd1, 5'd3,  5'd1,  5'd1,  2'd0},
      '{1'b1, 2'd3, 5'd5,  5'd1,  5'd0,  2'd2},
      // program B: independent
      '{1'b0, 2'd1, 5'd2,  5'd3,  5'd1,  2'd0},
      '{1'b0, 2'd1, 5'd5,  5'd6,  5'd4,  2'd0},
      '{1'b0, 2'd1, 5'd8,  5'd9,  5'd7,  2'd0},
      '{1'b1, 2'd1, 5'd11, 5'd12, 5'd10, 2'd0},
      // program C: distance two (R7)
      '{1'b0, 2'd1, 5'd2,  5'd3,  5'd1,  2'd0},
      '{1'b0, 2'd1, 5'd3,  5'd4,  5'd2,  2'd0},
      '{1'b1, 2'd1, 5'd1,  5'd0,  5'd5,  2'd1},
      // program D: distance three, write-back producer (R5)
      '{1'b0, 2'd1, 5'd2,  5'd3,  5'd1,  2'd0},
      '{1'b0, 2'd1, 5'd5,  5'd6,  5'd4,  2'd0},
      '{1'b0, 2'd1, 5'd8,  5'd9,  5'd7,  2'd0},
      '{1'b1, 2'd1, 5'd1,  5'd1,  5'd10, 2'd0},
      // program E: false dependences (R3, R4)
      '{1'b0, 2'd1, 5'd2,  5'd3,  5'd0,  2'd0},
      '{1'b0, 2'd1, 5'd0,  5'd0,  5'd3,  2'd0},
      '{1'b0, 2'd3, 5'd9,  5'd10, 5'd11, 2'd0},
      '{1'b0, 2'd1, 5'd11, 5'd11, 5'd12, 2'd0},
      '{1'b0, 2'd2, 5'd1,  5'd0,  5'd7,  2'd0},
      '{1'b0, 2'd2, 5'd2,  5'd7,  5'd8,  2'd0},
      '{1'b0, 2'd0, 5'd8,  5'd8,  5'd8,  2'd0},
      '{1'b1, 2'd1, 5'd8,  5'd0,  5'd13, 2'd1},
      // program F: store data field dependence
      '{1'b0, 2'd1, 5'd2,  5'd3,  5'd4,  2'd0},
      '{1'b1, 2'd3, 5'd0,  5'd4,  5'd0,  2'd2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_valid = 1'b0;
   logic [1:0]    fetch_cls = '0;
   logic [RW-1:0] fetch_rs = '0, fetch_rt = '0, fetch_rd = '0;
   logic          pc_we, ifid_hold, idex_bubble, wb_valid, wb_wen;
   logic [RW-1:0] wb_rd;

   int n_chk = 0;
   int n_bad = 0;
   int scnt [NV];

   always #2 clk = ~clk;

   pil_interlock #(.REG_W(RW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_valid (fetch_valid),
      .fetch_cls   (fetch_cls),
      .fetch_rs    (fetch_rs),
      .fetch_rt    (fetch_rt),
      .fetch_rd    (fetch_rd),
      .pc_we       (pc_we),
      .ifid_hold   (ifid_hold),
      .idex_bubble (idex_bubble),
      .wb_valid    (wb_valid),
      .wb_wen      (wb_wen),
      .wb_rd       (wb_rd)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      fetch_valid = 1'b0;
      fetch_cls = '0; fetch_rs = '0; fetch_rt = '0; fetch_rd = '0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // run one program from VEC[s] to its last entry; at entry we sit just after a negedge
   task automatic run_prog(input int s, input bit is_chain);
      int e, n, nxt, id_i, ret, cyc, total, exp_total;
      bit stl;
      e = s;
      while (!VEC[e].last) e++;
      n = e - s + 1;
      nxt = s; id_i = -1; ret = 0; cyc = 0; total = -1;
      exp_total = n + 4;
      for (int i = s; i <= e; i++) begin
         scnt[i] = 0;
         exp_total += int'(VEC[i].stl);
      end
      while (ret < n && cyc < 100) begin
         if (nxt <= e) begin
            fetch_valid = 1'b1;
            fetch_cls = VEC[nxt].cls; fetch_rs = VEC[nxt].rs;
            fetch_rt = VEC[nxt].rt;   fetch_rd = VEC[nxt].rd;
         end else begin
            fetch_valid = 1'b0;
            fetch_cls = '0; fetch_rs = '0; fetch_rt = '0; fetch_rd = '0;
         end
         #1;
         cyc++;
         stl = !pc_we;
         // R6: control outputs agree with the stall
         chk("R6 hold", int'(ifid_hold), int'(stl));
         chk("R6 bubble", int'(idex_bubble), int'(stl));
         if (stl && id_i >= 0) scnt[id_i]++;
         if (stl && id_i < 0) chk("R2 stall with empty decode", 1, 0);
         if (wb_valid) begin
            // R1 order and destination, R3 write flag
            chk("R1 retire rd", int'(wb_rd), int'(VEC[s+ret].rd));
            chk("R3 retire wen", int'(wb_wen),
                int'(VEC[s+ret].cls == 2'd1 || VEC[s+ret].cls == 2'd2));
            ret++;
            if (ret == n) total = cyc;
         end
         @(posedge clk);
         if (!stl) begin
            if (nxt <= e) begin
               id_i = nxt;
               nxt++;
            end else begin
               id_i = -1;
            end
         end
         @(negedge clk);
      end
      for (int i = s; i <= e; i++)
         chk($sformatf("R2/R7 stall count instr %0d", i), scnt[i], int'(VEC[i].stl));
      chk("R1 total cycles", total, exp_total);
      if (is_chain) chk("R9 chain cycles", total, 15);
      idle(5);
   endtask

   initial begin : watchdog
      #(4 * 20000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int s;
      // R8: reset state with a live fetch
      fetch_valid = 1'b1; fetch_cls = 2'd1; fetch_rs = 5'd3; fetch_rt = 5'd3; fetch_rd = 5'd3;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 reset pc_we", int'(pc_we), 1);
      chk("R8 reset hold", int'(ifid_hold), 0);
      chk("R8 reset bubble", int'(idex_bubble), 0);
      chk("R8 reset wb_valid", int'(wb_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(6);

      // vector table
      s = 0;
      while (s < NV) begin
         run_prog(s, s == 0);
         while (!VEC[s].last) s++;
         s++;
      end

      // R8: reset while stalled
      fetch_valid = 1'b1; fetch_cls = 2'd1; fetch_rs = 5'd2; fetch_rt = 5'd2; fetch_rd = 5'd6;
      @(negedge clk);
      fetch_rs = 5'd6; fetch_rd = 5'd7;
      @(negedge clk);
      fetch_valid = 1'b0;
      #1;
      chk("R7 stall before reset", int'(pc_we), 0);
      rst_n = 1'b0;
      #1;
      chk("R8 stall cleared by reset", int'(pc_we), 1);
      chk("R8 wb empty after reset", int'(wb_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         #1;
         chk("R8 nothing retires after reset", int'(wb_valid), 0);
         @(negedge clk);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule